// File: doc/BRIEF.md
# Descriptor-List Audio DMA Channel

This block is a single bus-master DMA channel for an audio path. Software places a circular list of up to 32 buffer descriptors in memory and gives the channel the list's base address. Each descriptor is two 32-bit words: the buffer base address comes first, then a length word with flag bits. The channel fetches the descriptor at its current index over a simple memory read port. It then hands samples from a fill-side input stream to a link-side consumer, one 16-bit sample per link request, and counts the position within the current buffer down to zero.

Software sets a last valid index. When a buffer finishes with the current index equal to the last valid index, the channel halts and reports it. If software then moves the last valid index on, the channel resumes at the next entry. When a buffer ends and the current index differs from the last valid index, the channel steps to the next entry modulo 32. When the input stream is empty at a link request, the channel flags an underrun. In that case it sends either the previous sample again or zero, chosen per descriptor. Status bits are write-one-to-clear, and three of them can each be enabled onto a single interrupt line.

Top module: `dmac_channel`

## Requirements
- R1: After reset the channel reads back halted: status is 0x0001 (bit 0 halted), current and last valid indices are 0, position is 0, the prefetch index is 1, and irq, link_valid and mem_req_valid are 0. Registers are 32-bit words selected by reg_addr[3:2]. Word 0 is the list base. Word 1 holds the current index in [4:0], the last valid index in [12:8] and status in [31:16]. Word 2 holds the position in [15:0], the prefetch index in [20:16] and control in [31:24].
- R2: With control bit 0 (run) set and the channel halted without having finished its last valid buffer, it reads list_base+8*index (buffer base) and then list_base+8*index+4 (length word). It then presents the base on buf_addr and loads the position from length[15:0]. A request held without ready keeps its address stable.
- R3: A link request while a buffer is streaming, with input available and position nonzero, consumes the input sample (in_ready high) and decrements the position. link_valid with that sample follows one cycle after every link request.
- R4: A link request while streaming, with position nonzero and no input available, sets status bit 4 and leaves the position unchanged. The output is the last delivered sample if length bit 30 is 0, or zero if it is 1.
- R5: When the position reaches zero, status bit 3 is set if length bit 31 was set. If the current index differs from the last valid index, the current index steps by one modulo 32 and the next descriptor is fetched.
- R6: A buffer that ends with the current index equal to the last valid index sets status bit 2 and status bit 0 (halted). The channel stays halted until the last valid index changes.
- R7: Status bit 1 is set when a descriptor is loaded while the current index equals the last valid index.
- R8: Writing 1 to status bits 1 to 4 (word 1, byte lane 2) clears them; bit 0 only follows the halted state.
- R9: irq is high while any of these pairs are both set: status bit 3 and control bit 4, status bit 2 and control bit 2, status bit 4 and control bit 3. Status bit 1 never drives irq.
- R10: A link request while the channel is halted, paused (run 0) or fetching returns zero. It consumes no input, leaves the position unchanged and sets no status.
- R11: Writing a last valid index different from the current index while halted after the last valid buffer steps the current index by one modulo 32. If run is set, the channel then fetches that entry.
- R12: Writing control bit 1 clears the current and last valid indices, position, status and run on the next cycle, after which bit 1 reads 0. The list base and interrupt enables are kept.
- R13: The prefetch index always reads as the current index plus one modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address; bits [3:2] pick the word |
| reg_be | input | 4 | Byte lane enables for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| buf_addr | output | 32 | Base address of the current buffer |
| link_req | input | 1 | Link consumer asks for one sample |
| link_valid | output | 1 | Sample answer valid, one cycle after link_req |
| link_data | output | 16 | Sample answer |
| in_valid | input | 1 | Fill side has a sample |
| in_ready | output | 1 | Channel consumes the fill-side sample |
| in_data | input | 16 | Fill-side sample |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after buffer completion at the last valid index. A design that stepped past that index, or failed to mark it, would show a wrong index or a missing halt bit and would keep fetching. Underruns are driven under both fill modes and checked for an unchanged position. A design that decremented the position on a starved request would end its buffer early, and one that ignored the flag would send the wrong repeated or zero sample. The bench also wraps the index from 31 to 0, requests samples while paused or halted, clears status bits selectively, and issues a register reset mid-life. These catch an index that fails to wrap, a paused channel that consumes input, clears that touch the wrong bits, and a reset that loses the list base or enables.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = 32;
  localparam int SMP_W  = 16;
  localparam int POS_W  = 16;
  localparam int ST_W   = 16;
  localparam int LIST_LEN = 1 << IDX_W;

  localparam int ST_HALT = 0;
  localparam int ST_CELV = 1;
  localparam int ST_LVI  = 2;
  localparam int ST_IOC  = 3;
  localparam int ST_FIFO = 4;

  localparam int CTL_RUN   = 0;
  localparam int CTL_RR    = 1;
  localparam int CTL_LVBIE = 2;
  localparam int CTL_FEIE  = 3;
  localparam int CTL_IOCE  = 4;

  localparam int LEN_IOC_BIT  = 31;
  localparam int LEN_ZERO_BIT = 30;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [SMP_W-1:0]  smp_t;

  typedef enum logic [2:0] {
    S_HALT, S_REQ_BASE, S_WAIT_BASE, S_REQ_LEN, S_WAIT_LEN, S_STREAM
  } seq_state_t;

  function automatic idx_t idx_inc(idx_t i);
    return i + idx_t'(1);
  endfunction

  function automatic addr_t desc_word_addr(addr_t base, idx_t i, logic second);
    return base + (addr_t'(i) << 3) + (second ? addr_t'(4) : addr_t'(0));
  endfunction

  function automatic logic [4:1] sticky_next(logic [4:1] cur, logic [4:1] set,
                                             logic [4:1] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_of(logic [4:1] st, logic en_lvi, logic en_fifo,
                                  logic en_ioc);
    return (st[ST_IOC] & en_ioc) | (st[ST_LVI] & en_lvi) | (st[ST_FIFO] & en_fifo);
  endfunction
endpackage

// File: rtl/dmac_sequencer.sv
module dmac_sequencer
  import dmac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  run,
  input  addr_t list_base,
  input  idx_t  lvi,
  input  logic  lvi_wr,
  input  idx_t  lvi_new,
  input  logic  pos_zero,
  input  logic  mem_req_ready,
  input  logic  mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic  mem_req_valid,
  output addr_t mem_req_addr,
  output idx_t  civ,
  output logic  halted,
  output logic  done_lvi,
  output logic  streaming,
  output logic  desc_load,
  output pos_t  desc_len,
  output logic  zero_fill,
  output addr_t buf_addr,
  output logic  ev_celv,
  output logic  ev_lvi_done,
  output logic  ev_ioc
);
  seq_state_t state_q;
  idx_t  civ_q;
  logic  done_q, ioc_q, zero_q;
  addr_t buf_q;
  logic  buf_end, at_last;

  assign at_last   = (civ_q == lvi);
  assign buf_end   = (state_q == S_STREAM) && run && pos_zero;
  assign desc_load = (state_q == S_WAIT_LEN) && mem_rsp_valid;
  assign desc_len  = mem_rsp_data[POS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HALT;
      civ_q   <= '0;
      done_q  <= 1'b0;
      ioc_q   <= 1'b0;
      zero_q  <= 1'b0;
      buf_q   <= '0;
    end else if (soft_clr) begin
      state_q <= S_HALT;
      civ_q   <= '0;
      done_q  <= 1'b0;
      ioc_q   <= 1'b0;
      zero_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      case (state_q)
        S_HALT: begin
          if (done_q) begin
            if (lvi_wr && (lvi_new != civ_q)) begin
              civ_q  <= idx_inc(civ_q);
              done_q <= 1'b0;
            end
          end else if (run) begin
            state_q <= S_REQ_BASE;
          end
        end
        S_REQ_BASE:  if (mem_req_ready) state_q <= S_WAIT_BASE;
        S_WAIT_BASE: if (mem_rsp_valid) begin
          buf_q   <= mem_rsp_data;
          state_q <= S_REQ_LEN;
        end
        S_REQ_LEN:   if (mem_req_ready) state_q <= S_WAIT_LEN;
        S_WAIT_LEN:  if (mem_rsp_valid) begin
          ioc_q   <= mem_rsp_data[LEN_IOC_BIT];
          zero_q  <= mem_rsp_data[LEN_ZERO_BIT];
          state_q <= S_STREAM;
        end
        S_STREAM: if (buf_end) begin
          if (at_last) begin
            done_q  <= 1'b1;
            state_q <= S_HALT;
          end else begin
            civ_q   <= idx_inc(civ_q);
            state_q <= S_REQ_BASE;
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign mem_req_valid = (state_q == S_REQ_BASE) || (state_q == S_REQ_LEN);
  assign mem_req_addr  = desc_word_addr(list_base, civ_q, state_q == S_REQ_LEN);
  assign civ         = civ_q;
  assign halted      = (state_q == S_HALT);
  assign done_lvi    = done_q;
  assign streaming   = (state_q == S_STREAM);
  assign zero_fill   = zero_q;
  assign buf_addr    = buf_q;
  assign ev_celv     = desc_load && at_last;
  assign ev_lvi_done = buf_end && at_last;
  assign ev_ioc      = buf_end && ioc_q;
endmodule

// File: rtl/dmac_sampler.sv
module dmac_sampler
  import dmac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic desc_load,
  input  pos_t desc_len,
  input  logic zero_fill,
  input  logic active,
  input  logic link_req,
  input  logic in_valid,
  input  smp_t in_data,
  output logic in_ready,
  output logic link_valid,
  output smp_t link_data,
  output pos_t pos,
  output logic pos_zero,
  output logic ev_underrun
);
  pos_t pos_q;
  smp_t last_q, data_q;
  logic valid_q;
  logic serve, take;

  assign pos_zero    = (pos_q == '0);
  assign serve       = link_req && active && !pos_zero;
  assign take        = serve && in_valid;
  assign ev_underrun = serve && !in_valid;
  assign in_ready    = serve;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      last_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (soft_clr) begin
      pos_q   <= '0;
      last_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= link_req;
      if (desc_load)  pos_q <= desc_len;
      else if (take)  pos_q <= pos_q - pos_t'(1);
      if (take) begin
        data_q <= in_data;
        last_q <= in_data;
      end else if (ev_underrun) begin
        data_q <= zero_fill ? smp_t'(0) : last_q;
      end else if (link_req) begin
        data_q <= '0;
      end
    end
  end

  assign link_valid = valid_q;
  assign link_data  = data_q;
  assign pos        = pos_q;
endmodule

// File: rtl/dmac_status.sv
module dmac_status
  import dmac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic halted,
  input  logic ev_celv,
  input  logic ev_lvi,
  input  logic ev_ioc,
  input  logic ev_fifo,
  input  logic clr_we,
  input  logic [4:1] clr_mask,
  input  logic en_lvi,
  input  logic en_fifo,
  input  logic en_ioc,
  output logic [ST_W-1:0] status,
  output logic irq
);
  logic [4:1] sticky_q, set_v, clr_v;

  always_comb begin
    set_v          = '0;
    set_v[ST_CELV] = ev_celv;
    set_v[ST_LVI]  = ev_lvi;
    set_v[ST_IOC]  = ev_ioc;
    set_v[ST_FIFO] = ev_fifo;
    clr_v          = clr_we ? clr_mask : 4'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sticky_q <= '0;
    else if (soft_clr) sticky_q <= '0;
    else               sticky_q <= sticky_next(sticky_q, set_v, clr_v);
  end

  assign status = {{(ST_W-5){1'b0}}, sticky_q, halted};
  assign irq    = irq_of(sticky_q, en_lvi, en_fifo, en_ioc);
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic        link_req,
  output logic        link_valid,
  output logic [SMP_W-1:0] link_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [SMP_W-1:0] in_data,
  output logic        irq
);
  localparam int IPAD = 8 - IDX_W;

  addr_t base_q;
  idx_t  lvi_q;
  logic  run_q, rr_q, lvbie_q, feie_q, ioce_q;
  logic  wr_w0, wr_w1, wr_w2;
  logic  soft_clr, lvi_wr, clr_we, ctl_wr, active;
  idx_t  lvi_new, civ, piv;
  logic  halted, done_lvi, streaming, desc_load, zero_fill, pos_zero;
  pos_t  desc_len, pos;
  logic  ev_celv, ev_lvi_done, ev_ioc, ev_underrun;
  logic [ST_W-1:0] status;
  logic [7:0] ctrl;

  assign soft_clr = rr_q;
  assign wr_w0  = reg_we && (reg_addr[3:2] == 2'd0) && !rr_q;
  assign wr_w1  = reg_we && (reg_addr[3:2] == 2'd1) && !rr_q;
  assign wr_w2  = reg_we && (reg_addr[3:2] == 2'd2) && !rr_q;
  assign lvi_wr = wr_w1 && reg_be[1];
  assign lvi_new = reg_wdata[8 +: IDX_W];
  assign clr_we = wr_w1 && reg_be[2];
  assign ctl_wr = wr_w2 && reg_be[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      lvi_q   <= '0;
      run_q   <= 1'b0;
      rr_q    <= 1'b0;
      lvbie_q <= 1'b0;
      feie_q  <= 1'b0;
      ioce_q  <= 1'b0;
    end else if (rr_q) begin
      lvi_q <= '0;
      run_q <= 1'b0;
      rr_q  <= 1'b0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (wr_w0 && reg_be[b]) base_q[8*b +: 8] <= reg_wdata[8*b +: 8];
      if (lvi_wr) lvi_q <= lvi_new;
      if (ctl_wr) begin
        run_q   <= reg_wdata[24 + CTL_RUN];
        rr_q    <= reg_wdata[24 + CTL_RR];
        lvbie_q <= reg_wdata[24 + CTL_LVBIE];
        feie_q  <= reg_wdata[24 + CTL_FEIE];
        ioce_q  <= reg_wdata[24 + CTL_IOCE];
      end
    end
  end

  assign active = streaming && run_q;
  assign piv    = idx_inc(civ);
  assign ctrl   = {3'b000, ioce_q, feie_q, lvbie_q, rr_q, run_q};

  dmac_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .run(run_q),
    .list_base(base_q), .lvi(lvi_q), .lvi_wr(lvi_wr), .lvi_new(lvi_new),
    .pos_zero(pos_zero), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .civ(civ), .halted(halted), .done_lvi(done_lvi), .streaming(streaming),
    .desc_load(desc_load), .desc_len(desc_len), .zero_fill(zero_fill),
    .buf_addr(buf_addr), .ev_celv(ev_celv), .ev_lvi_done(ev_lvi_done),
    .ev_ioc(ev_ioc)
  );

  dmac_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .desc_load(desc_load),
    .desc_len(desc_len), .zero_fill(zero_fill), .active(active),
    .link_req(link_req), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .link_valid(link_valid), .link_data(link_data),
    .pos(pos), .pos_zero(pos_zero), .ev_underrun(ev_underrun)
  );

  dmac_status u_st (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .halted(halted),
    .ev_celv(ev_celv), .ev_lvi(ev_lvi_done), .ev_ioc(ev_ioc),
    .ev_fifo(ev_underrun), .clr_we(clr_we),
    .clr_mask(reg_wdata[16+ST_FIFO:16+ST_CELV]),
    .en_lvi(lvbie_q), .en_fifo(feie_q), .en_ioc(ioce_q),
    .status(status), .irq(irq)
  );

  always_comb begin
    case (reg_addr[3:2])
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = {status, {IPAD{1'b0}}, lvi_q, {IPAD{1'b0}}, civ};
      2'd2:    reg_rdata = {ctrl, {IPAD{1'b0}}, piv, pos};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk
  import dmac_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic soft_clr,
  input logic rr_q,
  input logic active,
  input logic link_req,
  input logic link_valid,
  input logic in_valid,
  input pos_t pos,
  input logic pos_zero,
  input logic [ST_W-1:0] status,
  input logic irq,
  input logic halted,
  input logic done_lvi,
  input idx_t civ,
  input logic lvi_wr,
  input logic clr_we,
  input logic ctl_wr,
  input logic mem_req_valid,
  input logic mem_req_ready,
  input addr_t mem_req_addr
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !soft_clr |=> mem_req_valid && $stable(mem_req_addr));

  p_take_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active && link_req && in_valid && !pos_zero && !soft_clr |=> pos == $past(pos) - pos_t'(1));

  p_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_req && !soft_clr |=> link_valid);

  p_underrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active && link_req && !in_valid && !pos_zero && !soft_clr |=> status[ST_FIFO]);

  p_civ_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (civ != $past(civ)) && !$past(soft_clr) |-> civ == $past(civ) + idx_t'(1));

  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted && done_lvi && !lvi_wr && !soft_clr |=> halted);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_we && !ctl_wr && !soft_clr |=> irq);

  p_rr_selfclear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q |=> !rr_q);
endmodule

bind dmac_channel dmac_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rr_q(rr_q), .active(active),
  .link_req(link_req), .link_valid(link_valid), .in_valid(in_valid),
  .pos(pos), .pos_zero(pos_zero), .status(status), .irq(irq),
  .halted(halted), .done_lvi(done_lvi), .civ(civ), .lvi_wr(lvi_wr),
  .clr_we(clr_we), .ctl_wr(ctl_wr), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/dmac_channel_tb.sv
module dmac_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] buf_addr;
  logic        link_req = 1'b0;
  logic        link_valid;
  logic [15:0] link_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  dmac_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .buf_addr(buf_addr), .link_req(link_req),
    .link_valid(link_valid), .link_data(link_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .irq(irq)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    int i;
    i = int'((a & 32'h0000_0FFF) >> 3);
    if (a[15:12] == 4'h1) begin
      case (i)
        0: return a[2] ? 32'h8000_0003 : 32'h0000_A000;
        1: return a[2] ? 32'h4000_0002 : 32'h0000_A100;
        2: return a[2] ? 32'h8000_0002 : 32'h0000_A200;
        default: return 32'h0;
      endcase
    end
    return a[2] ? 32'h0 : (32'h0000_B000 + 32'(i) * 32'h10);
  endfunction

  always @(posedge clk) begin
    mem_req_ready <= ~mem_req_ready;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_word(mem_req_addr);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && link_valid) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nerr++;
        $display("FAIL R3 actual=%h expected=none (unexpected sample)", link_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (link_data !== e) begin
          nerr++;
          $display("FAIL R3/R4/R10 sample actual=%h expected=%h", link_data, e);
        end
      end
    end
  end

  task automatic wr(int word, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(word << 2); reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic rd(int word, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(word << 2);
    #1 d = reg_rdata;
  endtask

  task automatic send(logic v, logic [15:0] d, logic [15:0] e);
    @(negedge clk);
    link_req = 1'b1; in_valid = v; in_data = d;
    exp_q.push_back(e);
    @(negedge clk);
    link_req = 1'b0; in_valid = 1'b0;
  endtask

  task automatic wait_pos(string tag, logic [15:0] p);
    logic [31:0] d;
    d = '0;
    for (int k = 0; k < 200; k++) begin
      rd(2, d);
      if (d[15:0] == p) break;
    end
    chk(tag, {16'h0, d[15:0]}, {16'h0, p});
  endtask

  task automatic wait_lvi_done(string tag);
    logic [31:0] d;
    d = '0;
    for (int k = 0; k < 1000; k++) begin
      rd(1, d);
      if (d[18]) break;
    end
    chk(tag, {31'h0, d[18]}, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1, d); chk("R1 word1", d, 32'h0001_0000);
    rd(2, d); chk("R1 word2", d, 32'h0001_0000);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);

    // first list, last valid index 1, all enables, run
    wr(0, 4'hF, 32'h0000_1000);
    wr(1, 4'b0010, 32'h0000_0100);
    wr(2, 4'b1000, 32'h1D00_0000);
    wait_pos("R2 position load desc0", 16'd3);
    chk("R2 buf_addr desc0", buf_addr, 32'h0000_A000);

    send(1'b1, 16'h1111, 16'h1111);
    rd(2, d); chk("R3 position decrement", {16'h0, d[15:0]}, 32'd2);
    send(1'b0, 16'hDEAD, 16'h1111);
    rd(2, d); chk("R4 position held on underrun", {16'h0, d[15:0]}, 32'd2);
    rd(1, d); chk("R4 fifo error bit", {31'h0, d[20]}, 32'h1);
    chk("R9 irq from fifo error", {31'h0, irq}, 32'h1);
    wr(1, 4'b0100, 32'h0010_0000);
    rd(1, d); chk("R8 fifo bit cleared", d[31:16], 32'h0000);
    chk("R9 irq low after clear", {31'h0, irq}, 32'h0);

    send(1'b1, 16'h2222, 16'h2222);
    send(1'b1, 16'h3333, 16'h3333);
    wait_pos("R5 next descriptor loaded", 16'd2);
    rd(1, d);
    chk("R5 index stepped and ioc set", {d[31:16], d[7:0]}, {16'h0, 8'h0A, 8'h01});
    chk("R7 equal-index bit on load", {31'h0, d[17]}, 32'h1);
    chk("R2 buf_addr desc1", buf_addr, 32'h0000_A100);
    chk("R9 irq from completion", {31'h0, irq}, 32'h1);
    wr(1, 4'b0100, 32'h000A_0000);
    chk("R9 irq ignores equal-index bit", {31'h0, irq}, 32'h0);

    send(1'b0, 16'hBEEF, 16'h0000);
    wr(1, 4'b0100, 32'h0010_0000);
    send(1'b1, 16'h4444, 16'h4444);
    send(1'b1, 16'h5555, 16'h5555);
    repeat (4) @(negedge clk);
    rd(1, d); chk("R6 halted at last valid", d, 32'h0005_0101);
    chk("R9 irq from last valid", {31'h0, irq}, 32'h1);
    rd(2, d); chk("R13 prefetch index", d, 32'h1D02_0000);

    // R10 request while halted
    @(negedge clk);
    link_req = 1'b1; in_valid = 1'b1; in_data = 16'h6666;
    exp_q.push_back(16'h0000);
    #1 chk("R10 no input consumed when halted", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    link_req = 1'b0; in_valid = 1'b0;
    repeat (10) @(negedge clk);
    rd(1, d); chk("R6 stays halted, no fifo flag", d, 32'h0005_0101);

    // R11 resume by moving last valid index
    wr(1, 4'b0110, 32'h0004_0200);
    rd(1, d); chk("R11 index stepped on resume", {24'h0, d[7:0]}, 32'h02);
    wait_pos("R11 desc2 fetched", 16'd2);
    chk("R2 buf_addr desc2", buf_addr, 32'h0000_A200);

    // R10 pause
    wr(2, 4'b1000, 32'h1C00_0000);
    send(1'b1, 16'h7777, 16'h0000);
    rd(2, d); chk("R10 position held while paused", {16'h0, d[15:0]}, 32'd2);
    wr(2, 4'b1000, 32'h1D00_0000);
    send(1'b1, 16'h8888, 16'h8888);
    send(1'b1, 16'h9999, 16'h9999);
    repeat (4) @(negedge clk);
    rd(1, d); chk("R6 second halt with all flags", d, 32'h000F_0202);

    // R12 register reset
    wr(2, 4'b1000, 32'h1F00_0000);
    repeat (2) @(negedge clk);
    rd(1, d); chk("R12 indices and status cleared", d, 32'h0001_0000);
    rd(2, d); chk("R12 control after reset", d, 32'h1C01_0000);
    rd(0, d); chk("R12 base kept", d, 32'h0000_1000);
    chk("R12 irq low", {31'h0, irq}, 32'h0);

    // R5 wrap around the full list of empty buffers
    wr(0, 4'hF, 32'h0000_2000);
    wr(1, 4'b0010, 32'h0000_1F00);
    wr(2, 4'b1000, 32'h1D00_0000);
    wait_lvi_done("R6 list end reached");
    rd(1, d); chk("R5 index 31 reached", d, 32'h0007_1F1F);
    rd(2, d); chk("R13 prefetch wraps", d, 32'h1D00_0000);
    chk("R2 buf_addr entry 31", buf_addr, 32'h0000_B1F0);
    wr(1, 4'b0100, 32'h001E_0000);
    wr(1, 4'b0010, 32'h0000_0000);
    wait_lvi_done("R11 wrapped resume completes");
    rd(1, d); chk("R5 index wrapped to 0", d, 32'h0007_0000);
    chk("R2 buf_addr entry 0", buf_addr, 32'h0000_B000);

    repeat (3) @(negedge clk);
    chk("R3 all samples answered", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule